// File: doc/BRIEF.md
# Power-Down Sequencing Controller

This block orders the steps a clock generator takes when it enters and leaves its low-power state. An asynchronous, active-low power-down pin is first brought into the control clock domain. Every output clock group is then parked low, and the parking is held. The VCO enable drops only after a wait that gives the reference output time to settle low, and the crystal enable drops one cycle after the VCO enable. On release the crystal comes back first and the VCO one cycle later. A stabilization counter then runs to its end before the output groups are freed.

The controller runs on an always-on control clock, which is assumed to keep toggling while the oscillators are off. It drives one hold line for each output group: CPU, SDRAM, PCI, reference and 48 MHz. Three stop pins (CPU, PCI, SDRAM) can park their own group while the part is running. The oscillators and the clock gating cells are outside this block. Two parameters set the reference-park wait and the stabilization length.

Top module: `pd_seq_top`

## Requirements
- R1: A fall of `pdReqN` is synchronized through two flops. When the block is running, all hold outputs assert on the third rising edge of `clk` that follows the fall.
- R2: On entry, all five holds (`cpuHold`, `sdramHold`, `pciHold`, `refHold`, `usbHold`) assert in the same cycle.
- R3: `vcoEn` is deasserted exactly `PARK_CYC` edges after the holds assert, and it is never low while the power-down holds are clear.
- R4: `xtalEn` is deasserted one edge after `vcoEn`, and it is never low while `vcoEn` is high.
- R5: While the block is running, a low level on `cpuStopN`, `pciStopN` or `sdramStopN` asserts only that group's hold, on the second edge after the pin changes. `refHold` and `usbHold` are unaffected.
- R6: While power-down is in force, the stop pins have no effect, and every hold stays asserted whatever their level.
- R7: From sleep, a rise of `pdReqN` restores `xtalEn` on the third edge after the rise, and restores `vcoEn` one edge later.
- R8: All holds release `SETTLE_CYC` edges after `vcoEn` returns. The default of 32768 cycles is about 2.3 ms with a 14.318 MHz control clock, which is below the 3 ms power-up limit.
- R9: A release that arrives while the block is waiting for the reference output to park does not abort entry. Both oscillator enables still drop, and the exit sequence then follows.
- R10: While `rstN` is low, every hold is clear and both oscillator enables are high.
- R11: A new power-down request that arrives during stabilization lets stabilization finish. The holds release for at least one cycle before entry starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdReqN | input | 1 | Asynchronous power-down request, active low |
| cpuStopN | input | 1 | Asynchronous CPU group stop, active low |
| pciStopN | input | 1 | Asynchronous PCI group stop, active low |
| sdramStopN | input | 1 | Asynchronous SDRAM group stop, active low |
| cpuHold | output | 1 | Park the CPU outputs low |
| sdramHold | output | 1 | Park the SDRAM outputs low |
| pciHold | output | 1 | Park the PCI outputs low |
| refHold | output | 1 | Park the reference outputs low |
| usbHold | output | 1 | Park the 48 MHz outputs low |
| vcoEn | output | 1 | VCO enable |
| xtalEn | output | 1 | Crystal oscillator enable |

## Verification
The hardest situations to reach from the ports are the two overlaps. One is a release that lands inside the reference-park window (R9). The other is a new request that lands inside stabilization (R11). Each needs a pin edge placed a known number of cycles after a previous pin edge, with both synchronizer stages counted. The bench times these pulses from the pin edge and shortens the park and settle parameters so both windows are a few cycles wide. A cycle-by-cycle reference model then checks every output on every clock.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  localparam int SYNC_DEPTH = 2;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_PARK,
    ST_XOFF,
    ST_SLEEP,
    ST_XON,
    ST_SETTLE
  } seq_state_t;

  typedef struct packed {
    logic holdSet;
    logic holdClr;
    logic vcoOff;
    logic vcoOn;
    logic xtalOff;
    logic xtalOn;
  } seq_strobe_t;

endpackage

// File: rtl/pd_seq_ctrl.sv
module pd_seq_ctrl
  import pd_seq_pkg::*;
#(
  parameter int PARK_CYC   = 4,
  parameter int SETTLE_CYC = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pdAct,
  output seq_strobe_t strb
);

  localparam int MAX_C = (PARK_CYC > SETTLE_CYC) ? PARK_CYC : SETTLE_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PARK_LAST   = CNT_W'(PARK_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_t st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    strb    = '0;
    unique case (st)
      ST_RUN: begin
        if (pdAct) begin
          strb.holdSet = 1'b1;
          stNext       = ST_PARK;
          cntNext      = '0;
        end
      end
      ST_PARK: begin
        // entry is never aborted: pdAct is not consulted here
        if (cnt == PARK_LAST) begin
          strb.vcoOff = 1'b1;
          stNext      = ST_XOFF;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_XOFF: begin
        strb.xtalOff = 1'b1;
        stNext       = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!pdAct) begin
          strb.xtalOn = 1'b1;
          stNext      = ST_XON;
        end
      end
      ST_XON: begin
        strb.vcoOn = 1'b1;
        stNext     = ST_SETTLE;
        cntNext    = '0;
      end
      ST_SETTLE: begin
        if (cnt == SETTLE_LAST) begin
          strb.holdClr = 1'b1;
          stNext       = ST_RUN;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      default: stNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end

  a_r1_entry_starts: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && pdAct) |=> (st == ST_PARK));

  a_r3_park_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PARK) |-> (cnt <= PARK_LAST));

  a_r9_entry_not_aborted: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PARK) |=> (st == ST_PARK || st == ST_XOFF));

  a_r11_settle_completes: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SETTLE) |=> (st == ST_SETTLE || st == ST_RUN));

endmodule

// File: rtl/pd_seq_path.sv
module pd_seq_path
  import pd_seq_pkg::*;
#(
  parameter int NSTOP = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdReqN,
  input  logic [NSTOP-1:0] stopReqN,
  input  seq_strobe_t      strb,
  output logic             pdAct,
  output logic [NSTOP-1:0] stopHold,
  output logic             allHold,
  output logic             vcoEn,
  output logic             xtalEn
);

  logic [SYNC_DEPTH-1:0] pdSh;
  logic [NSTOP-1:0]      stopSync;
  logic                  pdHoldQ, vcoEnQ, xtalEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdSh <= '0;
    else       pdSh <= {pdSh[SYNC_DEPTH-2:0], ~pdReqN};
  end
  assign pdAct = pdSh[SYNC_DEPTH-1];

  for (genvar g = 0; g < NSTOP; g++) begin : gStop
    logic [SYNC_DEPTH-1:0] sh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sh <= '0;
      else       sh <= {sh[SYNC_DEPTH-2:0], ~stopReqN[g]};
    end
    assign stopSync[g] = sh[SYNC_DEPTH-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdHoldQ <= 1'b0;
      vcoEnQ  <= 1'b1;
      xtalEnQ <= 1'b1;
    end else begin
      if (strb.holdSet)      pdHoldQ <= 1'b1;
      else if (strb.holdClr) pdHoldQ <= 1'b0;
      if (strb.vcoOff)       vcoEnQ  <= 1'b0;
      else if (strb.vcoOn)   vcoEnQ  <= 1'b1;
      if (strb.xtalOff)      xtalEnQ <= 1'b0;
      else if (strb.xtalOn)  xtalEnQ <= 1'b1;
    end
  end

  assign allHold  = pdHoldQ;
  assign stopHold = stopSync | {NSTOP{pdHoldQ}};
  assign vcoEn    = vcoEnQ;
  assign xtalEn   = xtalEnQ;

  a_r3_vco_off_needs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !vcoEnQ |-> pdHoldQ);

  a_r4_xtal_off_needs_vco_off: assert property (@(posedge clk) disable iff (!rstN)
    !xtalEnQ |-> !vcoEnQ);

  a_r2_hold_precedes_vco_off: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vcoEnQ) |-> $past(pdHoldQ));

  a_r8_release_with_osc_on: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pdHoldQ) |-> (vcoEnQ && xtalEnQ));

endmodule

// File: rtl/pd_seq_top.sv
module pd_seq_top
  import pd_seq_pkg::*;
#(
  parameter int PARK_CYC   = 4,
  parameter int SETTLE_CYC = 32768
) (
  input  logic clk,
  input  logic rstN,
  input  logic pdReqN,
  input  logic cpuStopN,
  input  logic pciStopN,
  input  logic sdramStopN,
  output logic cpuHold,
  output logic sdramHold,
  output logic pciHold,
  output logic refHold,
  output logic usbHold,
  output logic vcoEn,
  output logic xtalEn
);

  localparam int NSTOP = 3;

  seq_strobe_t      strb;
  logic             pdAct;
  logic             allHold;
  logic [NSTOP-1:0] stopHold;

  pd_seq_ctrl #(
    .PARK_CYC  (PARK_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .pdAct(pdAct),
    .strb (strb)
  );

  pd_seq_path #(
    .NSTOP(NSTOP)
  ) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .pdReqN  (pdReqN),
    .stopReqN({sdramStopN, pciStopN, cpuStopN}),
    .strb    (strb),
    .pdAct   (pdAct),
    .stopHold(stopHold),
    .allHold (allHold),
    .vcoEn   (vcoEn),
    .xtalEn  (xtalEn)
  );

  assign cpuHold   = stopHold[0];
  assign pciHold   = stopHold[1];
  assign sdramHold = stopHold[2];
  assign refHold   = allHold;
  assign usbHold   = allHold;

endmodule

// File: tb/pd_seq_top_tb_top.sv
module pd_seq_top_tb_top;

  localparam int P = 6;
  localparam int S = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdN = 1'b1, cpuN = 1'b1, pciN = 1'b1, sdrN = 1'b1;
  logic cpuHold, sdramHold, pciHold, refHold, usbHold, vcoEn, xtalEn;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pd_seq_top #(.PARK_CYC(P), .SETTLE_CYC(S)) dut_i (
    .clk(clk), .rstN(rstN), .pdReqN(pdN),
    .cpuStopN(cpuN), .pciStopN(pciN), .sdramStopN(sdrN),
    .cpuHold(cpuHold), .sdramHold(sdramHold), .pciHold(pciHold),
    .refHold(refHold), .usbHold(usbHold), .vcoEn(vcoEn), .xtalEn(xtalEn)
  );

  // behavioural reference model
  bit  pdSeen[$];
  bit  mHold, mVco, mXtal;
  bit  mCpuRaw, mCpuS, mPciRaw, mPciS, mSdrRaw, mSdrS;
  int  phase, cnt;

  always @(posedge clk or negedge rstN) begin
    bit seen;
    if (!rstN) begin
      pdSeen.delete();
      mHold = 0; mVco = 1; mXtal = 1; phase = 0; cnt = 0;
      mCpuRaw = 0; mCpuS = 0; mPciRaw = 0; mPciS = 0; mSdrRaw = 0; mSdrS = 0;
    end else begin
      seen = (pdSeen.size() == 2) ? pdSeen[0] : 1'b0;
      pdSeen.push_back(!pdN);
      if (pdSeen.size() > 2) void'(pdSeen.pop_front());
      mCpuS = mCpuRaw; mCpuRaw = !cpuN;
      mPciS = mPciRaw; mPciRaw = !pciN;
      mSdrS = mSdrRaw; mSdrRaw = !sdrN;
      case (phase)
        0: if (seen) begin mHold = 1; phase = 1; cnt = 0; end
        1: if (cnt == P - 1) begin mVco = 0; phase = 2; end else cnt++;
        2: begin mXtal = 0; phase = 3; end
        3: if (!seen) begin mXtal = 1; phase = 4; end
        4: begin mVco = 1; phase = 5; cnt = 0; end
        default: if (cnt == S - 1) begin mHold = 0; phase = 0; end else cnt++;
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 refHold model", refHold, mHold);
      chk("R2 usbHold model", usbHold, mHold);
      chk("R5 cpuHold model", cpuHold, mHold | mCpuS);
      chk("R5 pciHold model", pciHold, mHold | mPciS);
      chk("R5 sdramHold model", sdramHold, mHold | mSdrS);
      chk("R3 vcoEn model", vcoEn, mVco);
      chk("R4 xtalEn model", xtalEn, mXtal);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit sawOff, sawRel, sawBack;
    tick(2);
    // R10 reset state
    chk("R10 cpuHold", cpuHold, 1'b0);
    chk("R10 refHold", refHold, 1'b0);
    chk("R10 vcoEn", vcoEn, 1'b1);
    chk("R10 xtalEn", xtalEn, 1'b1);
    rstN = 1'b1;
    tick(3);

    // R5 stop pins while running
    cpuN = 1'b0;
    tick(1); chk("R5 cpu not yet", cpuHold, 1'b0);
    tick(1); chk("R5 cpu held", cpuHold, 1'b1);
    chk("R5 ref untouched", refHold, 1'b0);
    chk("R5 pci untouched", pciHold, 1'b0);
    cpuN = 1'b1; sdrN = 1'b0;
    tick(2); chk("R5 sdram held", sdramHold, 1'b1);
    sdrN = 1'b1; tick(3);

    // R1 entry timing
    pdN = 1'b0;
    tick(2); chk("R1 hold not before third edge", refHold, 1'b0);
    tick(1); chk("R1 hold on third edge", refHold, 1'b1);
    chk("R2 all groups", cpuHold & pciHold & sdramHold & usbHold, 1'b1);
    tick(P - 1); chk("R3 vco during park", vcoEn, 1'b1);
    tick(1); chk("R3 vco off", vcoEn, 1'b0);
    chk("R4 xtal still on", xtalEn, 1'b1);
    tick(1); chk("R4 xtal off", xtalEn, 1'b0);

    // R6 stop pins ignored in power-down
    pciN = 1'b0; cpuN = 1'b0; tick(3);
    pciN = 1'b1; cpuN = 1'b1; tick(3);
    chk("R6 pci still held", pciHold, 1'b1);
    chk("R6 cpu still held", cpuHold, 1'b1);

    // R7 / R8 exit timing
    pdN = 1'b1;
    tick(2); chk("R7 xtal not yet", xtalEn, 1'b0);
    tick(1); chk("R7 xtal back", xtalEn, 1'b1);
    chk("R7 vco not yet", vcoEn, 1'b0);
    tick(1); chk("R7 vco back", vcoEn, 1'b1);
    tick(S - 1); chk("R8 held during settle", refHold, 1'b1);
    tick(1); chk("R8 released", refHold, 1'b0);
    tick(4);

    // R9 release inside the park window
    pdN = 1'b0; tick(4); pdN = 1'b1;
    sawOff = 0;
    for (int i = 0; i < 15; i++) begin tick(1); if (!xtalEn) sawOff = 1; end
    chk("R9 entry completed", sawOff, 1'b1);
    tick(S + 5);
    chk("R9 exit followed", refHold, 1'b0);

    // R11 request during settle
    pdN = 1'b0; tick(3 + P + 2); pdN = 1'b1;
    tick(5); pdN = 1'b0;
    sawRel = 0; sawBack = 0;
    for (int i = 0; i < S + 15; i++) begin
      tick(1);
      if (!refHold) sawRel = 1;
      else if (sawRel) sawBack = 1;
    end
    chk("R11 release before re-entry", sawRel, 1'b1);
    chk("R11 re-entry", sawBack, 1'b1);
    pdN = 1'b1;
    tick(P + S + 12);
    chk("R8 final run", refHold, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule